// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block watches a 64-bit ECC-protected memory datapath from the side. Each cycle the datapath may flag a correctable (single-bit) or uncorrectable (multi-bit) error for the beat it is handling. It also presents that beat's data word, check byte and address. The unit keeps a sticky status flag per error class and counts correctable errors against a programmable threshold. It records the details of the first error it sees and drives a level interrupt. Software works through a small 32-bit word-addressed register port: writes land on the clock edge and reads are combinational.

The same unit owns error injection for the write path. A 64-bit data mask, split into an upper and a lower 32-bit register, and an 8-bit check mask are XORed onto outgoing write data and check bytes. This happens only while a global enable bit is set. Diagnostics can therefore plant known faults and then watch the capture side report them.

Register word addresses: 0 status, 1 suppress, 2 interrupt enable, 3 correctable-error control, 4 captured data upper, 5 captured data lower, 6 captured check byte, 7 captured address lower, 8 captured address upper, 9 injection mask upper, 10 injection mask lower, 11 injection control. Any other address reads zero.

Top module: `mec_err_monitor`

## Requirements
- R1: Status register bit 0 is the correctable flag and bit 1 is the uncorrectable flag. An accepted uncorrectable event sets bit 1 on the clock edge at which it is presented.
- R2: Writing the status register clears exactly those flags whose data bit is 1. Writing all ones clears both flags, and a zero bit leaves its flag unchanged.
- R3: In the suppress register, bit 0 masks correctable events and bit 1 masks uncorrectable events. A masked event sets no flag, does not advance the counter and is not captured. A value of zero accepts everything.
- R4: The correctable-control register holds the threshold in bits 23:16 and shows the running count in bits 7:0. Each accepted correctable event advances the count. The event that brings the count to the threshold sets the correctable flag and returns the count to 0. A threshold of 0 or 1 flags every such event. Writing the register loads the threshold and zeroes the count.
- R5: In the interrupt-enable register, bit 0 enables the correctable flag and bit 1 enables the uncorrectable flag. The interrupt output equals the OR of the enabled, set flags.
- R6: When an accepted event arrives while both flags are clear, the event is recorded. Its data goes to the upper and lower captured-data words, its check byte to bits 7:0 of the check register, and its address to the two address registers.
- R7: While either flag is set, the capture registers hold their contents regardless of further events.
- R8: The captured-address upper register returns address bits ADDR_W-1:32 zero-extended, and the lower register returns bits 31:0.
- R9: The two injection-mask registers read back as written. The injection-control register keeps bits 7:0 (check mask) and bit 8 (enable), and its other bits read 0.
- R10: With the enable bit set, write data leaves XORed with {upper mask, lower mask} and the check byte leaves XORed with the check mask, both combinationally. With the enable bit clear, both pass through unchanged.
- R11: After reset every register reads zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_sbe | input | 1 | Correctable error on this beat |
| ev_mbe | input | 1 | Uncorrectable error on this beat |
| ev_data | input | 64 | Data word of the beat |
| ev_chk | input | 8 | Check byte of the beat |
| ev_addr | input | 40 | Address of the beat |
| wr_data_i | input | 64 | Write-path data before injection |
| wr_chk_i | input | 8 | Write-path check byte before injection |
| wr_data_o | output | 64 | Write-path data after injection |
| wr_chk_o | output | 8 | Write-path check byte after injection |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that a register write and an error event which target the same flag never fall in the same cycle. They also assume that the threshold is never rewritten in the cycle a correctable event arrives, since the write takes priority and the event's count is lost. The stimulus presents events and register writes in separate cycles, one operation per task call. It changes the threshold only between event bursts, which keeps every property inside those limits.

// File: rtl/mec_pkg.sv
package mec_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 32;

   localparam logic [REG_AW-1:0] ADR_STATUS = 4'd0;
   localparam logic [REG_AW-1:0] ADR_SUPP   = 4'd1;
   localparam logic [REG_AW-1:0] ADR_IEN    = 4'd2;
   localparam logic [REG_AW-1:0] ADR_SBECTL = 4'd3;
   localparam logic [REG_AW-1:0] ADR_CDH    = 4'd4;
   localparam logic [REG_AW-1:0] ADR_CDL    = 4'd5;
   localparam logic [REG_AW-1:0] ADR_CCHK   = 4'd6;
   localparam logic [REG_AW-1:0] ADR_CAL    = 4'd7;
   localparam logic [REG_AW-1:0] ADR_CAH    = 4'd8;
   localparam logic [REG_AW-1:0] ADR_IJH    = 4'd9;
   localparam logic [REG_AW-1:0] ADR_IJL    = 4'd10;
   localparam logic [REG_AW-1:0] ADR_IJC    = 4'd11;

   localparam int THR_LSB   = 16;
   localparam int INJ_EN_BIT = 8;

   typedef struct packed {
      logic mbe;
      logic sbe;
   } err_pair_t;
endpackage

// File: rtl/mec_sbe_count.sv
module mec_sbe_count #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [THR_W-1:0] load_thr,
   input  logic             hit,
   output logic [THR_W-1:0] thr,
   output logic [THR_W-1:0] cnt,
   output logic             reach
);
   localparam int SUM_W = THR_W + 1;

   logic [SUM_W-1:0] nxt;

   if (THR_W < 1 || THR_W > 8) begin : g_bad_thr
      $error("mec_sbe_count: THR_W must be 1..8");
   end

   always_comb begin
      nxt   = {1'b0, cnt} + SUM_W'(1);
      reach = hit && (nxt >= {1'b0, thr});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr <= '0;
         cnt <= '0;
      end else if (load) begin
         thr <= load_thr;
         cnt <= '0;
      end else if (hit) begin
         cnt <= reach ? '0 : nxt[THR_W-1:0];
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '0) ? (cnt == '0) : (cnt < thr));
endmodule

// File: rtl/mec_capture.sv
module mec_capture #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              hold,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DATA_W-1:0] cap_data,
   output logic [CHK_W-1:0]  cap_chk,
   output logic [ADDR_W-1:0] cap_addr
);
   localparam int NWORDS = DATA_W / 32;

   logic load;

   if (DATA_W % 32 != 0) begin : g_bad_dw
      $error("mec_capture: DATA_W must be a multiple of 32");
   end

   assign load = take && !hold;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cap_data[w*32 +: 32] <= '0;
         else if (load) cap_data[w*32 +: 32] <= data_i[w*32 +: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_chk  <= '0;
         cap_addr <= '0;
      end else if (load) begin
         cap_chk  <= chk_i;
         cap_addr <= addr_i;
      end
   end

   // R7
   cap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(cap_data) && $stable(cap_chk) && $stable(cap_addr)));
endmodule

// File: rtl/mec_inject.sv
module mec_inject #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic              en,
   input  logic [DATA_W-1:0] mask,
   input  logic [CHK_W-1:0]  chk_mask,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHK_W-1:0]  chk_i,
   output logic [DATA_W-1:0] data_o,
   output logic [CHK_W-1:0]  chk_o
);
   localparam int NWORDS = DATA_W / 32;

   for (genvar w = 0; w < NWORDS; w++) begin : g_lane
      assign data_o[w*32 +: 32] = data_i[w*32 +: 32] ^ (en ? mask[w*32 +: 32] : 32'h0);
   end

   assign chk_o = chk_i ^ (en ? chk_mask : '0);
endmodule

// File: rtl/mec_err_monitor.sv
module mec_err_monitor
   import mec_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int ADDR_W = 40,
   parameter int THR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              ev_sbe,
   input  logic              ev_mbe,
   input  logic [DATA_W-1:0] ev_data,
   input  logic [CHK_W-1:0]  ev_chk,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [CHK_W-1:0]  wr_chk_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [CHK_W-1:0]  wr_chk_o,
   output logic              irq
);
   localparam int EXT_W = ADDR_W - 32;

   if (DATA_W != 64) begin : g_bad_dw
      $error("mec_err_monitor: DATA_W must be 64");
   end
   if (CHK_W < 1 || CHK_W > 8) begin : g_bad_cw
      $error("mec_err_monitor: CHK_W must be 1..8");
   end
   if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_aw
      $error("mec_err_monitor: ADDR_W must be 33..64");
   end

   err_pair_t        flags_q, supp_q, ien_q, set_v, clr_v;
   logic [31:0]      inj_hi_q, inj_lo_q;
   logic [CHK_W-1:0] inj_chk_q;
   logic             inj_en_q;
   logic             sbe_hit, mbe_hit, sbe_reach;
   logic [THR_W-1:0] thr, cnt;
   logic [DATA_W-1:0] cap_data;
   logic [CHK_W-1:0]  cap_chk;
   logic [ADDR_W-1:0] cap_addr;

   function automatic logic wr_to(input logic [REG_AW-1:0] a);
      return reg_wr && (reg_addr == a);
   endfunction

   assign sbe_hit = ev_sbe && !supp_q.sbe;
   assign mbe_hit = ev_mbe && !supp_q.mbe;

   mec_sbe_count #(.THR_W(THR_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_to(ADR_SBECTL)),
      .load_thr (reg_wdata[THR_LSB +: THR_W]),
      .hit      (sbe_hit),
      .thr      (thr),
      .cnt      (cnt),
      .reach    (sbe_reach)
   );

   mec_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (sbe_hit || mbe_hit),
      .hold     (flags_q.sbe || flags_q.mbe),
      .data_i   (ev_data),
      .chk_i    (ev_chk),
      .addr_i   (ev_addr),
      .cap_data (cap_data),
      .cap_chk  (cap_chk),
      .cap_addr (cap_addr)
   );

   mec_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj (
      .en       (inj_en_q),
      .mask     ({inj_hi_q, inj_lo_q}),
      .chk_mask (inj_chk_q),
      .data_i   (wr_data_i),
      .chk_i    (wr_chk_i),
      .data_o   (wr_data_o),
      .chk_o    (wr_chk_o)
   );

   always_comb begin
      set_v.sbe = sbe_reach;
      set_v.mbe = mbe_hit;
      clr_v     = wr_to(ADR_STATUS) ? err_pair_t'(reg_wdata[1:0]) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q   <= '0;
         supp_q    <= '0;
         ien_q     <= '0;
         inj_hi_q  <= '0;
         inj_lo_q  <= '0;
         inj_chk_q <= '0;
         inj_en_q  <= 1'b0;
      end else begin
         flags_q <= (flags_q & ~clr_v) | set_v;
         if (wr_to(ADR_SUPP)) supp_q   <= err_pair_t'(reg_wdata[1:0]);
         if (wr_to(ADR_IEN))  ien_q    <= err_pair_t'(reg_wdata[1:0]);
         if (wr_to(ADR_IJH))  inj_hi_q <= reg_wdata;
         if (wr_to(ADR_IJL))  inj_lo_q <= reg_wdata;
         if (wr_to(ADR_IJC)) begin
            inj_chk_q <= reg_wdata[CHK_W-1:0];
            inj_en_q  <= reg_wdata[INJ_EN_BIT];
         end
      end
   end

   assign irq = |(flags_q & ien_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADR_STATUS: reg_rdata[1:0] = flags_q;
         ADR_SUPP:   reg_rdata[1:0] = supp_q;
         ADR_IEN:    reg_rdata[1:0] = ien_q;
         ADR_SBECTL: begin
            reg_rdata[THR_LSB +: THR_W] = thr;
            reg_rdata[THR_W-1:0]        = cnt;
         end
         ADR_CDH:    reg_rdata = cap_data[63:32];
         ADR_CDL:    reg_rdata = cap_data[31:0];
         ADR_CCHK:   reg_rdata[CHK_W-1:0] = cap_chk;
         ADR_CAL:    reg_rdata = cap_addr[31:0];
         ADR_CAH:    reg_rdata[EXT_W-1:0] = cap_addr[ADDR_W-1:32];
         ADR_IJH:    reg_rdata = inj_hi_q;
         ADR_IJL:    reg_rdata = inj_lo_q;
         ADR_IJC: begin
            reg_rdata[CHK_W-1:0]  = inj_chk_q;
            reg_rdata[INJ_EN_BIT] = inj_en_q;
         end
         default:    reg_rdata = '0;
      endcase
   end

   // R1
   mbe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q.mbe) |-> $past(ev_mbe && !supp_q.mbe));

   // R2
   sbe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q.sbe) |-> $past(reg_wr && (reg_addr == ADR_STATUS) && reg_wdata[0]));

   // R5
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q == '0) |-> !irq);
endmodule

// File: tb/mec_err_monitor_tb.sv
`timescale 1ns/1ps
module mec_err_monitor_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ev_sbe = 1'b0, ev_mbe = 1'b0;
   logic [63:0] ev_data = '0;
   logic [7:0]  ev_chk = '0;
   logic [39:0] ev_addr = '0;
   logic [63:0] wr_data_i = '0;
   logic [7:0]  wr_chk_i = '0;
   logic [63:0] wr_data_o;
   logic [7:0]  wr_chk_o;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   mec_err_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_sbe(ev_sbe),
      .ev_mbe(ev_mbe), .ev_data(ev_data), .ev_chk(ev_chk), .ev_addr(ev_addr),
      .wr_data_i(wr_data_i), .wr_chk_i(wr_chk_i), .wr_data_o(wr_data_o),
      .wr_chk_o(wr_chk_o), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ev(input logic s, input logic m, input logic [63:0] d,
                     input logic [7:0] c, input logic [39:0] ad);
      @(negedge clk);
      ev_sbe = s; ev_mbe = m; ev_data = d; ev_chk = c; ev_addr = ad;
      @(negedge clk);
      ev_sbe = 1'b0; ev_mbe = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, {32'h0, v}, {32'h0, exp});
   endtask

   initial begin
      #150000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: every register zero after reset
      for (int a = 0; a < 12; a++) rd_chk("R11", 4'(a), 32'h0);
      check("R11 irq", {63'h0, irq}, 64'h0);

      // R9: read-back of injection registers
      wr(4'd9, 32'hDEAD_BEEF);
      wr(4'd10, 32'h0123_4567);
      wr(4'd11, 32'hFFFF_FFFF);
      rd_chk("R9 hi", 4'd9, 32'hDEAD_BEEF);
      rd_chk("R9 lo", 4'd10, 32'h0123_4567);
      rd_chk("R9 ctl", 4'd11, 32'h0000_01FF);

      // R10: single-bit data mask sweep, enabled and disabled
      wr_data_i = 64'hA5C3_0F96_1E2D_3C4B;
      wr_chk_i  = 8'h5A;
      for (int b = 0; b < 64; b++) begin
         logic [63:0] m;
         m = 64'h1 << b;
         wr(4'd9, m[63:32]);
         wr(4'd10, m[31:0]);
         wr(4'd11, 32'h100);
         #1 check("R10 on", wr_data_o, wr_data_i ^ m);
         wr(4'd11, 32'h000);
         #1 check("R10 off", wr_data_o, wr_data_i);
      end
      for (int b = 0; b < 8; b++) begin
         wr(4'd11, 32'h100 | (32'h1 << b));
         #1 check("R10 chk", {56'h0, wr_chk_o}, {56'h0, wr_chk_i ^ (8'h1 << b)});
      end
      wr(4'd11, 32'h0FF);
      #1 check("R10 chk off", {56'h0, wr_chk_o}, {56'h0, wr_chk_i});

      // R4: threshold sweep
      for (int t = 0; t <= 5; t++) begin
         int pre;
         pre = (t > 1) ? t - 1 : 0;
         wr(4'd0, 32'hFFFF_FFFF);
         wr(4'd3, 32'(t) << 16);
         for (int k = 0; k < pre; k++) ev(1'b1, 1'b0, 64'h0, 8'h0, 40'h0);
         rd_chk("R4 count", 4'd3, (32'(t) << 16) | 32'(pre));
         rd_chk("R4 no flag", 4'd0, 32'h0);
         ev(1'b1, 1'b0, 64'h0, 8'h0, 40'h0);
         rd_chk("R4 flag", 4'd0, 32'h1);
         rd_chk("R4 wrap", 4'd3, 32'(t) << 16);
      end

      // R6/R8: first capture, R7: freeze
      wr(4'd3, 32'h0001_0000);
      wr(4'd0, 32'hFFFF_FFFF);
      ev(1'b0, 1'b1, 64'h1111_2222_3333_4444, 8'hA7, 40'hAB_8765_4321);
      rd_chk("R1 mbe", 4'd0, 32'h2);
      rd_chk("R6 dh", 4'd4, 32'h1111_2222);
      rd_chk("R6 dl", 4'd5, 32'h3333_4444);
      rd_chk("R6 chk", 4'd6, 32'hA7);
      rd_chk("R8 al", 4'd7, 32'h8765_4321);
      rd_chk("R8 ah", 4'd8, 32'hAB);
      ev(1'b1, 1'b0, 64'h9999_8888_7777_6666, 8'h3C, 40'h12_0000_0000);
      rd_chk("R7 dh", 4'd4, 32'h1111_2222);
      rd_chk("R7 chk", 4'd6, 32'hA7);
      rd_chk("R7 ah", 4'd8, 32'hAB);
      rd_chk("R1 both", 4'd0, 32'h3);

      // R2: selective write-one-to-clear
      wr(4'd0, 32'h1);
      rd_chk("R2 clr sbe", 4'd0, 32'h2);
      rd_chk("R7 still", 4'd5, 32'h3333_4444);
      wr(4'd0, 32'h0);
      rd_chk("R2 zero", 4'd0, 32'h2);
      wr(4'd0, 32'h2);
      rd_chk("R2 clr mbe", 4'd0, 32'h0);
      ev(1'b1, 1'b0, 64'hCAFE_F00D_0BAD_BEEF, 8'h11, 40'h07_0000_0010);
      rd_chk("R6 new dh", 4'd4, 32'hCAFE_F00D);
      rd_chk("R6 new al", 4'd7, 32'h0000_0010);
      wr(4'd0, 32'hFFFF_FFFF);
      rd_chk("R2 all", 4'd0, 32'h0);

      // R3: suppression of each class
      for (int s = 1; s < 4; s++) begin
         wr(4'd1, 32'(s));
         wr(4'd3, 32'h0002_0000);
         ev(s[0], s[1], 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 40'hFF_FFFF_FFFF);
         rd_chk("R3 status", 4'd0, 32'h0);
         rd_chk("R3 count", 4'd3, 32'h0002_0000);
         rd_chk("R3 cap", 4'd4, 32'hCAFE_F00D);
      end
      wr(4'd1, 32'h0);
      wr(4'd3, 32'h0001_0000);

      // R5: interrupt enable x flag sweep
      for (int e = 0; e < 4; e++) begin
         for (int f = 0; f < 4; f++) begin
            wr(4'd2, 32'h0);
            wr(4'd0, 32'hFFFF_FFFF);
            if (f != 0) ev(f[0], f[1], 64'h0, 8'h0, 40'h0);
            wr(4'd2, 32'(e));
            #1 check("R5 irq", {63'h0, irq}, {63'h0, |(e[1:0] & f[1:0])});
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule